// File: doc/BRIEF.md
# CAN Acceptance Filter

This block decides whether a received CAN frame is kept or dropped. The receive logic presents a frame descriptor for one cycle: identifier, frame format, remote-request flag and the first two data bytes. The filter compares it against four programmable code bytes and four programmable mask bytes. One cycle later it returns a registered accept flag together with a result strobe.

A mode input selects the filter arrangement. In the first arrangement, one 32-bit comparison covers the whole descriptor. In the second, two narrower comparisons run side by side, and a hit in either one keeps the frame. A mask bit of 1 makes the matching bit a don't-care.

The code and mask bytes can only be changed while the controller is held in its reset (configuration) state. Writes at any other time are discarded, so the filter settings cannot change under live traffic.

Top module: `can_accept_filter`

## Requirements
- R1: `resultValid` is high in exactly the cycle after a cycle with `frameValid` high. `resultAccept` carries that frame's decision in the same cycle and is low whenever `resultValid` is low.
- R2: Each compared bit passes if its mask bit is 1. If the mask bit is 0, the bit passes only when the frame bit equals the code bit. A frame is accepted only if every compared bit of a filter passes.
- R3: With `dualMode`=0 and a standard frame, the 32-bit word {code byte0, byte1, byte2, byte3} (byte0 most significant) is compared against {id[10:0], rtr, 4 don't-care bits, data0, data1}. The four bits 19:16 always pass.
- R4: With `dualMode`=0 and an extended frame, the code word is compared against {id[28:0], rtr, 2 don't-care bits}. Bits 1:0 always pass and the data bytes are not used.
- R5: With `dualMode`=1 and a standard frame, the first filter works as follows. Byte0 together with byte1[7:5] is compared against id[10:0]. Byte1[4] is compared against rtr. Byte1[3:0] is compared against data0[7:4], and byte3[3:0] against data0[3:0].
- R6: With `dualMode`=1 and a standard frame, the second filter compares byte2 together with byte3[7:5] against id[10:0], and byte3[4] against rtr. Data bytes have no effect on it.
- R7: With `dualMode`=1 and an extended frame, the first filter compares {byte0, byte1} against id[28:13] and the second compares {byte2, byte3} against id[28:13]. Neither filter uses rtr, the lower identifier bits or the data.
- R8: With `dualMode`=1, a frame is accepted when either filter matches.
- R9: `frameFmt` encodes 2'b00 as standard and 2'b01 as extended. A frame with `frameFmt[1]`=1 is of unknown type and is always rejected.
- R10: A configuration write stores `cfgData` into code byte `cfgIdx` (`cfgSel`=0) or into mask byte `cfgIdx` (`cfgSel`=1). The write takes effect only when `inReset`=1 and is ignored otherwise.
- R11: After reset all code bytes are 0x00 and all mask bytes are 0xFF, so every frame of known type is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inReset | input | 1 | Controller is in configuration state; enables filter writes |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects a code byte, 1 selects a mask byte |
| cfgIdx | input | 2 | Byte index 0..3 |
| cfgData | input | 8 | Byte to store |
| dualMode | input | 1 | 0: one 32-bit filter, 1: two filters |
| frameValid | input | 1 | Frame descriptor valid this cycle |
| frameFmt | input | 2 | Frame format: 00 standard, 01 extended, 1x unknown |
| frameRtr | input | 1 | Remote-request flag |
| frameId | input | 29 | Identifier; standard frames use bits 10:0 |
| frameData0 | input | 8 | First data byte |
| frameData1 | input | 8 | Second data byte |
| resultValid | output | 1 | Decision strobe, one cycle after frameValid |
| resultAccept | output | 1 | Frame accepted |

## Verification
A decision is due exactly one clock edge after the edge that samples `frameValid`. The bench drives each descriptor on a falling edge and reads `resultValid` and `resultAccept` on the following falling edge, with the only register in the path between. A configuration byte is in place one edge after its write strobe, so every frame is sent after the last write has settled. In the back-to-back test, each result is read on the falling edge between two consecutive frames.

// File: rtl/can_filt_pkg.sv
`timescale 1ns/1ps
package can_filt_pkg;
  localparam int BYTE_W    = 8;
  localparam int ACC_BYTES = 4;
  localparam int WORD_W    = ACC_BYTES * BYTE_W;
  localparam int EXT_ID_W  = 29;
  localparam int STD_ID_W  = 11;
  localparam int DUAL_ID_W = 16;
  localparam int NUM_DUAL  = 2;
  localparam int DUAL_W    = STD_ID_W + 1 + BYTE_W;
  localparam int IDX_W     = $clog2(ACC_BYTES);

  typedef enum logic [1:0] {
    FMT_STD  = 2'b00,
    FMT_EXT  = 2'b01,
    FMT_UNK0 = 2'b10,
    FMT_UNK1 = 2'b11
  } frameFmt_e;

  typedef struct packed {
    logic [ACC_BYTES-1:0] codeWe;
    logic [ACC_BYTES-1:0] maskWe;
    logic                 evalEn;
  } filtStrobes_t;
endpackage

// File: rtl/can_filt_match.sv
`timescale 1ns/1ps
module can_filt_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] code,
  input  logic [W-1:0] mask,
  output logic         hit
);
  // a bit passes when it equals the code bit or is masked off
  assign hit = &(~(value ^ code) | mask);
endmodule

// File: rtl/can_filt_ctrl.sv
`timescale 1ns/1ps
module can_filt_ctrl
  import can_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inReset,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             frameValid,
  output filtStrobes_t     strobes,
  output logic             resultValid
);
  logic                 wrOk;
  logic [ACC_BYTES-1:0] codeWe;
  logic [ACC_BYTES-1:0] maskWe;

  // writes are honoured only in configuration state
  assign wrOk = cfgWrEn & inReset;

  for (genvar b = 0; b < ACC_BYTES; b++) begin : g_we
    assign codeWe[b] = wrOk & ~cfgSel & (cfgIdx == IDX_W'(b));
    assign maskWe[b] = wrOk &  cfgSel & (cfgIdx == IDX_W'(b));
  end

  always_comb begin
    strobes        = '0;
    strobes.codeWe = codeWe;
    strobes.maskWe = maskWe;
    strobes.evalEn = frameValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= frameValid;
  end
endmodule

// File: rtl/can_filt_datapath.sv
`timescale 1ns/1ps
module can_filt_datapath
  import can_filt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  filtStrobes_t        strobes,
  input  logic [BYTE_W-1:0]   cfgData,
  input  logic                dualMode,
  input  logic [1:0]          frameFmt,
  input  logic                frameRtr,
  input  logic [EXT_ID_W-1:0] frameId,
  input  logic [BYTE_W-1:0]   frameData0,
  input  logic [BYTE_W-1:0]   frameData1,
  output logic                resultAccept
);
  localparam logic [WORD_W-1:0] STD_FORCE = WORD_W'(32'h000F_0000);
  localparam logic [WORD_W-1:0] EXT_FORCE = WORD_W'(32'h0000_0003);

  logic [WORD_W-1:0]   codeWord;
  logic [WORD_W-1:0]   maskWord;
  logic                isStd;
  logic                isExt;
  logic [WORD_W-1:0]   singleVal;
  logic [WORD_W-1:0]   singleMask;
  logic                singleHit;
  logic [NUM_DUAL-1:0] dualHit;
  logic                acceptNext;

  // code and mask byte registers, byte 0 most significant in the word
  for (genvar b = 0; b < ACC_BYTES; b++) begin : g_acc
    logic [BYTE_W-1:0] codeQ;
    logic [BYTE_W-1:0] maskQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeQ <= '0;
        maskQ <= '1;
      end else begin
        if (strobes.codeWe[b]) codeQ <= cfgData;
        if (strobes.maskWe[b]) maskQ <= cfgData;
      end
    end
    assign codeWord[WORD_W-1-b*BYTE_W -: BYTE_W] = codeQ;
    assign maskWord[WORD_W-1-b*BYTE_W -: BYTE_W] = maskQ;
  end

  assign isStd = (frameFmt == FMT_STD);
  assign isExt = (frameFmt == FMT_EXT);

  // single wide filter
  always_comb begin
    if (isStd) begin
      singleVal  = {frameId[STD_ID_W-1:0], frameRtr, 4'h0, frameData0, frameData1};
      singleMask = maskWord | STD_FORCE;
    end else begin
      singleVal  = {frameId, frameRtr, 2'b00};
      singleMask = maskWord | EXT_FORCE;
    end
  end

  can_filt_match #(.W(WORD_W)) u_single (
    .value(singleVal),
    .code (codeWord),
    .mask (singleMask),
    .hit  (singleHit)
  );

  // two narrow filters; lane l owns bytes 2l and 2l+1
  for (genvar l = 0; l < NUM_DUAL; l++) begin : g_dual
    logic [BYTE_W-1:0] cHi, cLo, mHi, mLo, cLast, mLast;
    logic [DUAL_W-1:0] laneVal, laneCode, laneMask;

    assign cHi   = codeWord[WORD_W-1-(2*l)*BYTE_W -: BYTE_W];
    assign cLo   = codeWord[WORD_W-1-(2*l+1)*BYTE_W -: BYTE_W];
    assign mHi   = maskWord[WORD_W-1-(2*l)*BYTE_W -: BYTE_W];
    assign mLo   = maskWord[WORD_W-1-(2*l+1)*BYTE_W -: BYTE_W];
    assign cLast = codeWord[BYTE_W-1:0];
    assign mLast = maskWord[BYTE_W-1:0];

    always_comb begin
      if (isStd) begin
        if (l == 0) begin
          laneVal  = {frameId[STD_ID_W-1:0], frameRtr, frameData0};
          laneCode = {cHi, cLo, cLast[3:0]};
          laneMask = {mHi, mLo, mLast[3:0]};
        end else begin
          laneVal  = {frameId[STD_ID_W-1:0], frameRtr, {BYTE_W{1'b0}}};
          laneCode = {cHi, cLo[BYTE_W-1:4], {BYTE_W{1'b0}}};
          laneMask = {mHi, mLo[BYTE_W-1:4], {BYTE_W{1'b1}}};
        end
      end else begin
        laneVal  = {frameId[EXT_ID_W-1 -: DUAL_ID_W], 4'h0};
        laneCode = {cHi, cLo, 4'h0};
        laneMask = {mHi, mLo, 4'hF};
      end
    end

    can_filt_match #(.W(DUAL_W)) u_lane (
      .value(laneVal),
      .code (laneCode),
      .mask (laneMask),
      .hit  (dualHit[l])
    );
  end

  assign acceptNext = (isStd | isExt) & (dualMode ? (|dualHit) : singleHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resultAccept <= 1'b0;
    else if (strobes.evalEn) resultAccept <= acceptNext;
    else                     resultAccept <= 1'b0;
  end
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter
  import can_filt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inReset,
  input  logic                cfgWrEn,
  input  logic                cfgSel,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [BYTE_W-1:0]   cfgData,
  input  logic                dualMode,
  input  logic                frameValid,
  input  logic [1:0]          frameFmt,
  input  logic                frameRtr,
  input  logic [EXT_ID_W-1:0] frameId,
  input  logic [BYTE_W-1:0]   frameData0,
  input  logic [BYTE_W-1:0]   frameData1,
  output logic                resultValid,
  output logic                resultAccept
);
  filtStrobes_t strobes;

  can_filt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inReset    (inReset),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgIdx     (cfgIdx),
    .frameValid (frameValid),
    .strobes    (strobes),
    .resultValid(resultValid)
  );

  can_filt_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfgData     (cfgData),
    .dualMode    (dualMode),
    .frameFmt    (frameFmt),
    .frameRtr    (frameRtr),
    .frameId     (frameId),
    .frameData0  (frameData0),
    .frameData1  (frameData1),
    .resultAccept(resultAccept)
  );
endmodule

// File: rtl/can_filt_checker.sv
`timescale 1ns/1ps
module can_filt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       frameValid,
  input logic [1:0] frameFmt,
  input logic       resultValid,
  input logic       resultAccept
);
  // R1: strobe follows the frame by one cycle
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> resultValid);

  // R1: no strobe without a frame the cycle before
  a_r1_idle_next: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> !resultValid);

  // R1: accept only qualified by the strobe
  a_r1_accept_qualified: assert property (@(posedge clk) disable iff (!rstN)
    resultAccept |-> resultValid);

  // R9: unknown frame type never accepted
  a_r9_unknown_rejected: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameFmt[1]) |=> !resultAccept);
endmodule

bind can_accept_filter can_filt_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameValid  (frameValid),
  .frameFmt    (frameFmt),
  .resultValid (resultValid),
  .resultAccept(resultAccept)
);

// File: tb/can_accept_filter_test.sv
`timescale 1ns/1ps
module can_accept_filter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inReset = 1'b1;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [7:0]  cfgData = '0;
  logic        dualMode = 1'b0;
  logic        frameValid = 1'b0;
  logic [1:0]  frameFmt = '0;
  logic        frameRtr = 1'b0;
  logic [28:0] frameId = '0;
  logic [7:0]  frameData0 = '0;
  logic [7:0]  frameData1 = '0;
  logic        resultValid;
  logic        resultAccept;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  can_accept_filter uut (.*);

  typedef struct packed {
    logic        dual;
    logic [1:0]  fmt;
    logic        rtr;
    logic [28:0] id;
    logic [7:0]  d0;
    logic [7:0]  d1;
    logic [31:0] code;
    logic [31:0] mask;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h34, 32'hB4601234, 32'h0, 1'b1, 4'd3},      // R3 exact
    '{1'b0, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h35, 32'hB4601234, 32'h0, 1'b0, 4'd3},      // R3 data1 differs
    '{1'b0, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h35, 32'hB4601234, 32'h000000FF, 1'b1, 4'd2}, // R2 masked
    '{1'b0, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h34, 32'hB46F1234, 32'h0, 1'b1, 4'd3},      // R3 bits 19:16 pass
    '{1'b0, 2'b00, 1'b1, 29'h5A3, 8'h12, 8'h34, 32'hB4601234, 32'h0, 1'b0, 4'd3},      // R3 rtr differs
    '{1'b0, 2'b01, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, 32'hD5E6F7A8, 32'h0, 1'b1, 4'd4}, // R4 exact
    '{1'b0, 2'b01, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, 32'hD5E6F7AB, 32'h0, 1'b1, 4'd4}, // R4 bits 1:0 pass
    '{1'b0, 2'b01, 1'b1, 29'h1ABCDEF5, 8'h00, 8'h00, 32'hD5E6F7A8, 32'h0, 1'b0, 4'd4}, // R4 rtr differs
    '{1'b1, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h00, 32'hB4610002, 32'h0, 1'b1, 4'd5},      // R5 first filter
    '{1'b1, 2'b00, 1'b0, 29'h5A3, 8'h13, 8'h00, 32'hB4610002, 32'h0, 1'b0, 4'd5},      // R5 data0 low nibble
    '{1'b1, 2'b00, 1'b0, 29'h5A3, 8'hFF, 8'h00, 32'h0000B460, 32'h0, 1'b1, 4'd6},      // R6 data ignored
    '{1'b1, 2'b00, 1'b1, 29'h5A3, 8'hFF, 8'h00, 32'h0000B460, 32'h0, 1'b0, 4'd6},      // R6 rtr compared
    '{1'b1, 2'b01, 1'b1, 29'h1ABCDEF5, 8'h00, 8'h00, 32'hD5E60000, 32'h0, 1'b1, 4'd7}, // R7 first, rtr ignored
    '{1'b1, 2'b01, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, 32'h0000D5E6, 32'h0, 1'b1, 4'd8}, // R8 second only
    '{1'b1, 2'b01, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, 32'hD5E7D5E7, 32'h0, 1'b0, 4'd7}, // R7 neither
    '{1'b0, 2'b10, 1'b0, 29'h5A3, 8'h12, 8'h34, 32'h0, 32'hFFFFFFFF, 1'b0, 4'd9},      // R9 unknown
    '{1'b1, 2'b11, 1'b0, 29'h5A3, 8'h12, 8'h34, 32'h0, 32'hFFFFFFFF, 1'b0, 4'd9},      // R9 unknown dual
    '{1'b1, 2'b01, 1'b0, 29'h1ABCDEF5, 8'h00, 8'h00, 32'hD5E70000, 32'h00010000, 1'b1, 4'd2} // R2 dual mask bit
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic sel, input logic [1:0] idx, input logic [7:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgIdx = idx; cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic programAll(input logic [31:0] code, input logic [31:0] mask);
    for (int b = 0; b < 4; b++) begin
      writeByte(1'b0, 2'(b), code[31-8*b -: 8]);
      writeByte(1'b1, 2'(b), mask[31-8*b -: 8]);
    end
  endtask

  task automatic sendFrame(input logic dual, input logic [1:0] fmt, input logic rtr,
                           input logic [28:0] id, input logic [7:0] d0, input logic [7:0] d1,
                           output logic gotValid, output logic gotAccept);
    @(negedge clk);
    dualMode = dual; frameFmt = fmt; frameRtr = rtr; frameId = id;
    frameData0 = d0; frameData1 = d1; frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
    gotValid  = resultValid;
    gotAccept = resultAccept;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic v, a;
    repeat (3) @(negedge clk);
    check("R1 reset valid", resultValid, 1'b0);
    check("R1 reset accept", resultAccept, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle valid", resultValid, 1'b0);

    // R11: defaults accept any known frame
    sendFrame(1'b0, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h34, v, a);
    check("R11 std valid", v, 1'b1);
    check("R11 std accept", a, 1'b1);
    sendFrame(1'b1, 2'b01, 1'b1, 29'h0F0F0F0, 8'h00, 8'h00, v, a);
    check("R11 ext accept", a, 1'b1);
    @(negedge clk);
    check("R1 accept low after strobe", resultAccept, 1'b0);

    // R10: writes outside configuration state are dropped
    inReset = 1'b0;
    programAll(32'h55555555, 32'h00000000);
    sendFrame(1'b0, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h34, v, a);
    check("R10 ignored write", a, 1'b1);
    inReset = 1'b1;
    for (int b = 0; b < 4; b++) writeByte(1'b1, 2'(b), 8'h00);
    sendFrame(1'b0, 2'b00, 1'b0, 29'h5A3, 8'h12, 8'h34, v, a);
    check("R10 accepted write", a, 1'b0);

    // table of packing cases
    foreach (VECS[i]) begin
      programAll(VECS[i].code, VECS[i].mask);
      sendFrame(VECS[i].dual, VECS[i].fmt, VECS[i].rtr, VECS[i].id,
                VECS[i].d0, VECS[i].d1, v, a);
      check($sformatf("R%0d vector %0d valid", VECS[i].req, i), v, 1'b1);
      check($sformatf("R%0d vector %0d accept", VECS[i].req, i), a, VECS[i].exp);
    end

    // R1: back-to-back frames, each result one cycle later
    programAll(32'h00000000, 32'h00000000);
    @(negedge clk);
    dualMode = 1'b0; frameFmt = 2'b00; frameRtr = 1'b0;
    frameId = 29'h0; frameData0 = 8'h00; frameData1 = 8'h00; frameValid = 1'b1;
    @(negedge clk);
    frameId = 29'h1;
    check("R1 b2b first valid", resultValid, 1'b1);
    check("R1 b2b first accept", resultAccept, 1'b1);
    @(negedge clk);
    frameValid = 1'b0;
    check("R1 b2b second valid", resultValid, 1'b1);
    check("R1 b2b second accept", resultAccept, 1'b0);
    @(negedge clk);
    check("R1 b2b idle valid", resultValid, 1'b0);
    check("R1 b2b idle accept", resultAccept, 1'b0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule